// File: doc/BRIEF.md
# Four-Core Inter-Processor Interrupt Matrix

This block lets any of four processors interrupt any other (or itself). A core writes a target mask to a trigger register; the block records each call as one bit in a 4x4 sticky matrix of pending calls, indexed by the calling core (taken from the requester-ID input of the register bus) and the target core. Each target core gets one interrupt line that stays high while any caller is pending in its row.

Software clears calls in two ways. A core can see and clear its own callers through a per-core status view, which selects the row of the requesting core. Any core can see and clear any call through a global status view that exposes all sixteen matrix bits. A 3-bit priority value per core is also stored and driven out for downstream arbitration logic. It can be written either by the owning core through a per-core view or for all cores at once through a global view.

Register map (byte offsets on an 8-bit address): 0x40 trigger, 0x44 own status/clear, 0x48 own priority, 0x4C global status/clear, 0x50 global priority. Reads return data one cycle after the request. A two-state response machine controls this. RSP_IDLE moves to RSP_DATA on a read request. RSP_DATA stays in RSP_DATA on a further read and returns to RSP_IDLE otherwise. `rd_valid` is high in RSP_DATA.

Top module: `ipim_top`

## Requirements
- R1: A write to 0x40 from requester S sets matrix bit T*4+S for every T in 0..3 whose write-data bit T is 1. Write-data bits that are 0, and bits 31:4, have no effect.
- R2: A read of 0x4C returns the matrix in bits 15:0, where bit T*4+S means core S calls core T. Bits 31:16 read as zero.
- R3: A write to 0x4C clears every matrix bit whose write-data bit (15:0) is 1, from any requester. Bits written 0 are unchanged.
- R4: A read of 0x44 by requester T returns in bits 3:0 the row of callers of T: bit S is matrix bit T*4+S. The other bits read as zero.
- R5: A write to 0x44 by requester T clears matrix bit T*4+S for each write-data bit S (3:0) that is 1. Rows of other cores are unchanged.
- R6: `ipi_irq[T]` is high exactly when any bit of matrix row T is set. It follows the register edge that updates the matrix.
- R7: A write to 0x48 by requester C stores write-data bits 2:0 as the priority of core C. A read of 0x48 by C returns it in bits 2:0. `ipi_prio[3*C+2:3*C]` carries it.
- R8: A write to 0x50 stores the priority of core C from write-data bits 4*C+2:4*C for all four cores. A read returns the four priorities at the same offsets and zero elsewhere. It shares storage with the 0x48 view.
- R9: `rd_valid` is high in the cycle after each read request and low otherwise, with `rd_data` holding the value. 0x40 and unmapped addresses read as zero, and writes to unmapped addresses change nothing.
- R10: After reset the matrix, all priorities, `ipi_irq` and `rd_valid` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Register access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_src | input | 2 | ID of the requesting core |
| rd_valid | output | 1 | Read data valid (cycle after read request) |
| rd_data | output | 32 | Read data |
| ipi_irq | output | 4 | Per-core inter-processor interrupt line |
| ipi_prio | output | 12 | Stored 3-bit priority per core, core C at bits 3C+2:3C |

## Verification
The bench checks that a trigger lands in column S (the requester) rather than row S. A transposed index would raise the wrong interrupt line and put a different bit in the global view. It checks that a per-core clear reaches only the requester's row: clearing with the wrong index would wipe another core's pending calls. It checks that write-one-to-clear leaves bits written zero alone, and that upper trigger bits are ignored. It also checks that the two priority views share storage at offsets 0, 4, 8 and 12. A design with misplaced fields would return or drive the wrong core's priority.

// File: rtl/ipim_pkg.sv
package ipim_pkg;
    localparam int NCORE   = 4;
    localparam int ID_W    = 2;
    localparam int PRIO_W  = 3;
    localparam int PRIO_STRIDE = 4;
    localparam int ADDR_W  = 8;
    localparam int DATA_W  = 32;
    localparam int NPEND   = NCORE * NCORE;

    localparam logic [ADDR_W-1:0] OFS_TRIG      = 8'h40;
    localparam logic [ADDR_W-1:0] OFS_OWN_STAT  = 8'h44;
    localparam logic [ADDR_W-1:0] OFS_OWN_PRIO  = 8'h48;
    localparam logic [ADDR_W-1:0] OFS_ALL_STAT  = 8'h4C;
    localparam logic [ADDR_W-1:0] OFS_ALL_PRIO  = 8'h50;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_TRIG,
        SEL_OWN_STAT,
        SEL_OWN_PRIO,
        SEL_ALL_STAT,
        SEL_ALL_PRIO
    } reg_sel_e;

    typedef enum logic {
        RSP_IDLE,
        RSP_DATA
    } rsp_state_e;
endpackage

// File: rtl/ipim_decode.sv
module ipim_decode
    import ipim_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic [AW-1:0] addr,
    output reg_sel_e      sel
);
    always_comb begin
        unique case (addr)
            OFS_TRIG:     sel = SEL_TRIG;
            OFS_OWN_STAT: sel = SEL_OWN_STAT;
            OFS_OWN_PRIO: sel = SEL_OWN_PRIO;
            OFS_ALL_STAT: sel = SEL_ALL_STAT;
            OFS_ALL_PRIO: sel = SEL_ALL_PRIO;
            default:      sel = SEL_NONE;
        endcase
    end
endmodule

// File: rtl/ipim_matrix.sv
module ipim_matrix #(
    parameter int NC  = 4,
    parameter int IDW = 2,
    localparam int NP = NC * NC
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           trig_we,
    input  logic           own_clr_we,
    input  logic           all_clr_we,
    input  logic [IDW-1:0] src,
    input  logic [NP-1:0]  wdata,
    output logic [NP-1:0]  pend_q
);
    for (genvar t = 0; t < NC; t++) begin : g_tgt
        for (genvar s = 0; s < NC; s++) begin : g_src
            logic set_bit, clr_bit;
            assign set_bit = trig_we && (src == IDW'(s)) && wdata[t];
            assign clr_bit = (own_clr_we && (src == IDW'(t)) && wdata[s])
                          || (all_clr_we && wdata[t*NC+s]);
            // set has precedence so a call is never lost
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)       pend_q[t*NC+s] <= 1'b0;
                else if (set_bit) pend_q[t*NC+s] <= 1'b1;
                else if (clr_bit) pend_q[t*NC+s] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/ipim_prio.sv
module ipim_prio #(
    parameter int NC     = 4,
    parameter int IDW    = 2,
    parameter int PW     = 3,
    parameter int STRIDE = 4,
    parameter int DW     = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            own_we,
    input  logic            all_we,
    input  logic [IDW-1:0]  src,
    input  logic [DW-1:0]   wdata,
    output logic [NC*PW-1:0] prio_q
);
    for (genvar c = 0; c < NC; c++) begin : g_core
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                prio_q[c*PW +: PW] <= '0;
            else if (all_we)
                prio_q[c*PW +: PW] <= wdata[c*STRIDE +: PW];
            else if (own_we && (src == IDW'(c)))
                prio_q[c*PW +: PW] <= wdata[PW-1:0];
        end
    end

    logic unused_bits;
    assign unused_bits = ^wdata;
endmodule

// File: rtl/ipim_top.sv
module ipim_top
    import ipim_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [ID_W-1:0]   bus_src,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [NCORE-1:0]  ipi_irq,
    output logic [NCORE*PRIO_W-1:0] ipi_prio
);
    reg_sel_e            sel;
    rsp_state_e          state_q, state_d;
    logic [NPEND-1:0]    pend_q;
    logic [DATA_W-1:0]   rd_mux;
    logic                wr, rd;

    assign wr = bus_valid && bus_write;
    assign rd = bus_valid && !bus_write;

    ipim_decode #(.AW(ADDR_W)) u_dec (.addr(bus_addr), .sel(sel));

    ipim_matrix #(.NC(NCORE), .IDW(ID_W)) u_mtx (
        .clk(clk), .rst_n(rst_n),
        .trig_we(wr && sel == SEL_TRIG),
        .own_clr_we(wr && sel == SEL_OWN_STAT),
        .all_clr_we(wr && sel == SEL_ALL_STAT),
        .src(bus_src), .wdata(bus_wdata[NPEND-1:0]),
        .pend_q(pend_q)
    );

    ipim_prio #(.NC(NCORE), .IDW(ID_W), .PW(PRIO_W), .STRIDE(PRIO_STRIDE), .DW(DATA_W)) u_pri (
        .clk(clk), .rst_n(rst_n),
        .own_we(wr && sel == SEL_OWN_PRIO),
        .all_we(wr && sel == SEL_ALL_PRIO),
        .src(bus_src), .wdata(bus_wdata),
        .prio_q(ipi_prio)
    );

    for (genvar t = 0; t < NCORE; t++) begin : g_irq
        assign ipi_irq[t] = |pend_q[t*NCORE +: NCORE];
    end

    always_comb begin
        rd_mux = '0;
        unique case (sel)
            SEL_OWN_STAT: rd_mux[NCORE-1:0]  = pend_q[bus_src*NCORE +: NCORE];
            SEL_OWN_PRIO: rd_mux[PRIO_W-1:0] = ipi_prio[bus_src*PRIO_W +: PRIO_W];
            SEL_ALL_STAT: rd_mux[NPEND-1:0]  = pend_q;
            SEL_ALL_PRIO: begin
                for (int c = 0; c < NCORE; c++)
                    rd_mux[c*PRIO_STRIDE +: PRIO_W] = ipi_prio[c*PRIO_W +: PRIO_W];
            end
            default: rd_mux = '0;
        endcase
    end

    // response state machine: next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RSP_IDLE: if (rd) state_d = RSP_DATA;
            RSP_DATA: if (!rd) state_d = RSP_IDLE;
            default:  state_d = RSP_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RSP_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  rd_data <= '0;
        else if (rd) rd_data <= rd_mux;
    end
    assign rd_valid = (state_q == RSP_DATA);
endmodule

// File: rtl/ipim_checker.sv
module ipim_checker
    import ipim_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [ID_W-1:0]   bus_src,
    input logic              rd_valid,
    input logic [NCORE-1:0]  ipi_irq,
    input logic [NPEND-1:0]  pend_q
);
    logic is_trig, is_oclr, is_gclr, is_rd;
    logic [NPEND-1:0] tmask, rmask;

    assign is_trig = bus_valid && bus_write && bus_addr == OFS_TRIG;
    assign is_oclr = bus_valid && bus_write && bus_addr == OFS_OWN_STAT;
    assign is_gclr = bus_valid && bus_write && bus_addr == OFS_ALL_STAT;
    assign is_rd   = bus_valid && !bus_write;

    always_comb begin
        tmask = '0;
        rmask = '0;
        for (int t = 0; t < NCORE; t++) begin
            tmask[t*NCORE + int'(bus_src)] = bus_wdata[t];
            for (int s = 0; s < NCORE; s++)
                if (t == int'(bus_src)) rmask[t*NCORE+s] = 1'b1;
        end
    end

    a_r1_trigger_sets: assert property (@(posedge clk) disable iff (!rst_n)
        is_trig |=> ((pend_q & $past(tmask)) == $past(tmask)));

    a_r1_only_trigger_raises: assert property (@(posedge clk) disable iff (!rst_n)
        !is_trig |=> ((pend_q & ~$past(pend_q)) == '0));

    a_r3_global_clear: assert property (@(posedge clk) disable iff (!rst_n)
        is_gclr |=> (pend_q == ($past(pend_q) & ~$past(bus_wdata[NPEND-1:0]))));

    a_r5_row_isolated: assert property (@(posedge clk) disable iff (!rst_n)
        is_oclr |=> ((pend_q & ~$past(rmask)) == ($past(pend_q) & ~$past(rmask))));

    a_r6_irq_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        ((ipi_irq != '0) == (pend_q != '0)));

    a_r9_read_valid: assert property (@(posedge clk) disable iff (!rst_n)
        is_rd |=> rd_valid);

    a_r9_no_stray_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !is_rd |=> !rd_valid);
endmodule

bind ipim_top ipim_checker u_chk (.*);

// File: tb/ipim_top_bench.sv
module ipim_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [1:0]  bus_src = '0;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic [3:0]  ipi_irq;
    logic [11:0] ipi_prio;

    int vectors = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    ipim_top u_ipim_top (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [1:0] s);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d; bus_src = s;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rdreg(input logic [7:0] a, input logic [1:0] s, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a; bus_src = s;
        @(negedge clk);
        bus_valid = 1'b0;
        chk("R9 rd_valid after read", {31'b0, rd_valid}, 32'd1);
        d = rd_data;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R10 irq after reset", {28'b0, ipi_irq}, 32'h0);
        chk("R10 prio after reset", {20'b0, ipi_prio}, 32'h0);
        chk("R10 rd_valid after reset", {31'b0, rd_valid}, 32'h0);
        rdreg(8'h4C, 2'd0, d);
        chk("R10 matrix after reset", d, 32'h0);
    endtask

    task automatic t_trigger();
        logic [31:0] d;
        wr(8'h40, 32'hFFFF_FFF5, 2'd1);        // core1 -> cores 0,2
        rdreg(8'h4C, 2'd0, d);
        chk("R1 R2 trigger from core1", d, 32'h0000_0202);
        chk("R6 irq rows 0,2", {28'b0, ipi_irq}, 32'h5);
        wr(8'h40, 32'h8, 2'd3);                // core3 -> core3
        rdreg(8'h4C, 2'd2, d);
        chk("R1 R2 self call core3", d, 32'h0000_8202);
        chk("R6 irq rows 0,2,3", {28'b0, ipi_irq}, 32'hD);
        wr(8'h40, 32'h0, 2'd2);                // zero mask: nothing
        rdreg(8'h4C, 2'd2, d);
        chk("R1 zero trigger no effect", d, 32'h0000_8202);
    endtask

    task automatic t_own_view();
        logic [31:0] d;
        rdreg(8'h44, 2'd2, d);
        chk("R4 core2 callers", d, 32'h2);
        wr(8'h40, 32'h4, 2'd0);                // core0 -> core2, bit 8
        rdreg(8'h44, 2'd2, d);
        chk("R4 core2 callers after core0 call", d, 32'h3);
        wr(8'h44, 32'hF, 2'd0);                // core0 clears its row
        rdreg(8'h4C, 2'd1, d);
        chk("R5 row0 cleared, others kept", d, 32'h0000_8300);
        chk("R6 irq after row0 clear", {28'b0, ipi_irq}, 32'hC);
        wr(8'h44, 32'h1, 2'd2);                // core2 clears source 0 only
        rdreg(8'h4C, 2'd1, d);
        chk("R5 single bit clear in row2", d, 32'h0000_8200);
    endtask

    task automatic t_global_clear();
        logic [31:0] d;
        wr(8'h4C, 32'h0000_8000, 2'd0);
        rdreg(8'h4C, 2'd0, d);
        chk("R3 clear one bit", d, 32'h0000_0200);
        chk("R6 irq row2 only", {28'b0, ipi_irq}, 32'h4);
        wr(8'h4C, 32'h0, 2'd1);
        rdreg(8'h4C, 2'd0, d);
        chk("R3 zero write keeps bits", d, 32'h0000_0200);
        wr(8'h4C, 32'hFFFF_FFFF, 2'd3);
        rdreg(8'h4C, 2'd0, d);
        chk("R3 clear all", d, 32'h0);
        chk("R6 irq all low", {28'b0, ipi_irq}, 32'h0);
    endtask

    task automatic t_prio();
        logic [31:0] d;
        wr(8'h48, 32'h0000_00FD, 2'd1);
        rdreg(8'h48, 2'd1, d);
        chk("R7 core1 own prio", d, 32'h5);
        rdreg(8'h48, 2'd0, d);
        chk("R7 core0 prio untouched", d, 32'h0);
        chk("R7 prio output", {20'b0, ipi_prio}, 32'h028);
        rdreg(8'h50, 2'd3, d);
        chk("R8 global view of core1", d, 32'h0000_0050);
        wr(8'h50, 32'h7654_3217, 2'd0);
        chk("R8 prio output after global write", {20'b0, ipi_prio}, 32'h68F);
        rdreg(8'h50, 2'd0, d);
        chk("R8 global prio readback", d, 32'h0000_3217);
        rdreg(8'h48, 2'd2, d);
        chk("R8 shared storage core2", d, 32'h2);
    endtask

    task automatic t_misc();
        logic [31:0] d;
        rdreg(8'h10, 2'd0, d);
        chk("R9 unmapped reads zero", d, 32'h0);
        @(negedge clk);
        chk("R9 rd_valid drops", {31'b0, rd_valid}, 32'h0);
        wr(8'h54, 32'hFFFF_FFFF, 2'd1);
        rdreg(8'h4C, 2'd0, d);
        chk("R9 unmapped write no matrix change", d, 32'h0);
        chk("R9 unmapped write no prio change", {20'b0, ipi_prio}, 32'h68F);
        wr(8'h40, 32'h2, 2'd0);
        rdreg(8'h40, 2'd0, d);
        chk("R9 trigger reads zero", d, 32'h0);
        rdreg(8'h4C, 2'd0, d);
        chk("R1 core0 -> core1 bit 4", d, 32'h0000_0010);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_trigger();
        t_own_view();
        t_global_clear();
        t_prio();
        t_misc();
        repeat (2) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        vectors++;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule